// File: doc/BRIEF.md
# Multiplexed GPIO Line Controller

This block runs one bank of general-purpose I/O lines (12 by default; two banks give 24 lines). Each line is owned either by software or by an on-chip peripheral. A line owned by software is an input or an output, set by a direction bit, and drives the value held in an output-data register. A line handed to the peripheral passes the peripheral's drive value and enable to the pad unchanged.

On the input side every pad goes through a two-flop synchronizer. The synchronized level is given to the peripheral as it is. For software it then passes an optional per-line glitch filter, which produces the level that software reads back. Any change of that level latches a per-line status bit. The interrupt output is the OR of the status bits that are enabled by a mask. Reading the status register returns the bits and clears them.

The register port is a simple word bus. A write takes effect on the clock edge where `wr_en` is high. `rdata` is combinational while `rd_en` is high and is zero otherwise. Separate set and clear addresses let software change single output or direction bits without a read-modify-write.

Top module: `gpx_bank`

## Requirements
- R1: After synchronous reset, every line is owned by software as an input: `pad_oe` is all zero, `irq` is 0, the STAT and MASK registers read 0, and the OWN register reads all ones.
- R2: For a line whose OWN bit (address 0) is 1, `pad_oe` equals its DIR bit (address 1, where 1 means output) and `pad_out` equals its DOUT bit (address 2).
- R3: For a line whose OWN bit is 0, `pad_out` and `pad_oe` follow `per_out` and `per_oe` of that line, and the DIR and DOUT bits have no effect on the pad.
- R4: A write to DOUT_SET (3) or DIR_SET (5) sets exactly the bits that are 1 in `wdata`. A write to DOUT_CLR (4) or DIR_CLR (6) clears exactly those bits. All other bits keep their value.
- R5: With the filter off, a pad level held across three rising edges is visible in PIN (address 9) after the third edge and not after the second.
- R6: With the FILT bit (address 7) set, a pad pulse lasting one clock is never seen in PIN and sets no status bit. A held level reaches PIN one edge later than with the filter off.
- R7: Every change of a line's PIN level sets its STAT bit (address 10). `irq` is 1 exactly when some STAT bit is set together with its MASK bit (address 8).
- R8: A read of STAT returns the bits and clears them. A change that lands on the same clock edge as the read stays set.
- R9: `per_in` presents the two-flop synchronized pad level after the second rising edge, regardless of OWN and FILT.
- R10: OWN, DIR, DOUT, FILT and MASK read back the value written. A write to PIN or to STAT has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears STAT when reading it) |
| addr | input | 4 | Register word address |
| wdata | input | NLINES | Write data |
| rdata | output | NLINES | Read data, zero when not reading |
| pad_in | input | NLINES | Pad input levels |
| pad_out | output | NLINES | Pad drive values |
| pad_oe | output | NLINES | Pad output enables |
| per_out | input | NLINES | Peripheral drive values |
| per_oe | input | NLINES | Peripheral output enables |
| per_in | output | NLINES | Synchronized pad level to the peripheral |
| irq | output | 1 | Masked change interrupt |

## Verification
The collision that matters is a status read and a freshly detected input change on the same clock edge. If the clear wins, an event is lost without any trace. The bench leaves one line's change pending, then times a second line's change so that its PIN update falls on exactly the edge that ends the STAT read. The first read must return only the old bit. A second read must return the new bit, and `irq` must stay high between the two reads.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        RA_OWN      = 4'd0,
        RA_DIR      = 4'd1,
        RA_DOUT     = 4'd2,
        RA_DOUT_SET = 4'd3,
        RA_DOUT_CLR = 4'd4,
        RA_DIR_SET  = 4'd5,
        RA_DIR_CLR  = 4'd6,
        RA_FILT     = 4'd7,
        RA_MASK     = 4'd8,
        RA_PIN      = 4'd9,
        RA_STAT     = 4'd10
    } gpx_reg_e;

    typedef struct packed {
        logic out;
        logic oe;
    } pad_drv_t;

    function automatic logic reg_hit(input logic en, input logic [ADDR_W-1:0] a,
                                     input gpx_reg_e r);
        return en && (a == r);
    endfunction

endpackage

// File: rtl/gpx_regs.sv
module gpx_regs
    import gpx_pkg::*;
#(
    parameter int NLINES = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NLINES-1:0] wdata,
    input  logic [NLINES-1:0] pin_lvl,
    input  logic [NLINES-1:0] chg,
    output logic [NLINES-1:0] own,
    output logic [NLINES-1:0] dir,
    output logic [NLINES-1:0] dout,
    output logic [NLINES-1:0] filt,
    output logic [NLINES-1:0] mask,
    output logic [NLINES-1:0] stat,
    output logic [NLINES-1:0] rdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            own  <= '1;
            dir  <= '0;
            dout <= '0;
            filt <= '0;
            mask <= '0;
            stat <= '0;
        end else begin
            if (reg_hit(wr_en, addr, RA_OWN))      own  <= wdata;
            if (reg_hit(wr_en, addr, RA_FILT))     filt <= wdata;
            if (reg_hit(wr_en, addr, RA_MASK))     mask <= wdata;
            if (reg_hit(wr_en, addr, RA_DOUT))     dout <= wdata;
            if (reg_hit(wr_en, addr, RA_DOUT_SET)) dout <= dout | wdata;
            if (reg_hit(wr_en, addr, RA_DOUT_CLR)) dout <= dout & ~wdata;
            if (reg_hit(wr_en, addr, RA_DIR))      dir  <= wdata;
            if (reg_hit(wr_en, addr, RA_DIR_SET))  dir  <= dir | wdata;
            if (reg_hit(wr_en, addr, RA_DIR_CLR))  dir  <= dir & ~wdata;
            // new events win over the clear-on-read
            if (reg_hit(rd_en, addr, RA_STAT))     stat <= chg;
            else                                   stat <= stat | chg;
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (addr)
                RA_OWN:  rdata = own;
                RA_DIR:  rdata = dir;
                RA_DOUT: rdata = dout;
                RA_FILT: rdata = filt;
                RA_MASK: rdata = mask;
                RA_PIN:  rdata = pin_lvl;
                RA_STAT: rdata = stat;
                default: rdata = '0;
            endcase
        end
    end

    // R8
    stat_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == RA_STAT) |=> ((stat & ~$past(chg)) == '0));

    // R7
    chg_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (chg != '0) |=> ((stat & $past(chg)) == $past(chg)));

    // R4
    dout_set_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == RA_DOUT_SET) |=> ((dout & $past(wdata)) == $past(wdata)));

    // R4
    dout_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == RA_DOUT_CLR) |=> ((dout & $past(wdata)) == '0));

endmodule

// File: rtl/gpx_infilt.sv
module gpx_infilt #(
    parameter int NLINES = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NLINES-1:0] pad_in,
    input  logic [NLINES-1:0] filt,
    output logic [NLINES-1:0] sync_lvl,
    output logic [NLINES-1:0] lvl,
    output logic [NLINES-1:0] chg
);

    logic [NLINES-1:0] s1, s2, s3;
    logic [NLINES-1:0] lvl_nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1  <= '0;
            s2  <= '0;
            s3  <= '0;
            lvl <= '0;
        end else begin
            s1  <= pad_in;
            s2  <= s1;
            s3  <= s2;
            lvl <= lvl_nxt;
        end
    end

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        // filtered: accept only when two consecutive samples agree
        assign lvl_nxt[i] = filt[i] ? ((s2[i] == s3[i]) ? s2[i] : lvl[i]) : s2[i];

        // R6
        filt_stable_chk: assert property (@(posedge clk) disable iff (rst)
            ($past(filt[i]) && (lvl[i] != $past(lvl[i]))) |-> ($past(s2[i]) == $past(s3[i])));
    end

    assign chg      = lvl_nxt ^ lvl;
    assign sync_lvl = s2;

endmodule

// File: rtl/gpx_padmux.sv
module gpx_padmux
    import gpx_pkg::*;
#(
    parameter int NLINES = 12
) (
    input  logic [NLINES-1:0] own,
    input  logic [NLINES-1:0] dir,
    input  logic [NLINES-1:0] dout,
    input  logic [NLINES-1:0] per_out,
    input  logic [NLINES-1:0] per_oe,
    output logic [NLINES-1:0] pad_out,
    output logic [NLINES-1:0] pad_oe
);

    for (genvar i = 0; i < NLINES; i++) begin : g_mux
        pad_drv_t sw_drv, per_drv, sel_drv;
        assign sw_drv  = '{out: dout[i],    oe: dir[i]};
        assign per_drv = '{out: per_out[i], oe: per_oe[i]};
        assign sel_drv = own[i] ? sw_drv : per_drv;
        assign pad_out[i] = sel_drv.out;
        assign pad_oe[i]  = sel_drv.oe;
    end

endmodule

// File: rtl/gpx_bank.sv
module gpx_bank
    import gpx_pkg::*;
#(
    parameter int NLINES = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NLINES-1:0] wdata,
    output logic [NLINES-1:0] rdata,
    input  logic [NLINES-1:0] pad_in,
    output logic [NLINES-1:0] pad_out,
    output logic [NLINES-1:0] pad_oe,
    input  logic [NLINES-1:0] per_out,
    input  logic [NLINES-1:0] per_oe,
    output logic [NLINES-1:0] per_in,
    output logic              irq
);

    logic [NLINES-1:0] own, dir, dout, filt, mask, stat;
    logic [NLINES-1:0] lvl, chg;

    gpx_regs #(.NLINES(NLINES)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .pin_lvl(lvl), .chg(chg), .own(own), .dir(dir),
        .dout(dout), .filt(filt), .mask(mask), .stat(stat), .rdata(rdata)
    );

    gpx_infilt #(.NLINES(NLINES)) u_in (
        .clk(clk), .rst(rst), .pad_in(pad_in), .filt(filt),
        .sync_lvl(per_in), .lvl(lvl), .chg(chg)
    );

    gpx_padmux #(.NLINES(NLINES)) u_mux (
        .own(own), .dir(dir), .dout(dout), .per_out(per_out), .per_oe(per_oe),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    assign irq = |(stat & mask);

    // R7
    irq_src_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(irq) && $stable(mask)) |-> ($past(chg) != '0));

endmodule

// File: tb/sim_gpx_bank.sv
module sim_gpx_bank;
    localparam int NL = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [3:0]    addr = '0;
    logic [NL-1:0] wdata = '0;
    logic [NL-1:0] rdata;
    logic [NL-1:0] pad_in = '0;
    logic [NL-1:0] pad_out, pad_oe;
    logic [NL-1:0] per_out = '0;
    logic [NL-1:0] per_oe = '0;
    logic [NL-1:0] per_in;
    logic          irq;

    int checks = 0;
    int errors = 0;
    logic [NL-1:0] rv;

    always #2 clk = ~clk;

    gpx_bank #(.NLINES(NL)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .per_out(per_out), .per_oe(per_oe), .per_in(per_in),
        .irq(irq)
    );

    task automatic chk(input string req, input logic [NL-1:0] act, input logic [NL-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [NL-1:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a);
        rd_en = 1'b1; addr = a;
        #1 rv = rdata;
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); @(negedge clk);
        end
    endtask

    task automatic t_reset;
        chk("R1 pad_oe", pad_oe, '0);
        chk("R1 irq", {11'b0, irq}, '0);
        rd(4'd10); chk("R1 stat", rv, '0);
        rd(4'd8);  chk("R1 mask", rv, '0);
        rd(4'd0);  chk("R1 own", rv, 12'hFFF);
    endtask

    task automatic t_gpio_drive;
        wr(4'd1, 12'h00F);
        wr(4'd2, 12'h005);
        chk("R2 pad_oe", pad_oe, 12'h00F);
        chk("R2 pad_out", pad_out, 12'h005);
        rd(4'd1); chk("R10 dir readback", rv, 12'h00F);
        wr(4'd7, 12'h0A0); rd(4'd7); chk("R10 filt readback", rv, 12'h0A0);
        wr(4'd7, 12'h000);
        wr(4'd9, 12'hFFF); rd(4'd9); chk("R10 pin write ignored", rv, 12'h000);
        wr(4'd10, 12'hFFF); rd(4'd10); chk("R10 stat write ignored", rv, 12'h000);
    endtask

    task automatic t_setclr;
        wr(4'd3, 12'h0A0); chk("R4 dout set", pad_out, 12'h0A5);
        wr(4'd4, 12'h001); chk("R4 dout clr", pad_out, 12'h0A4);
        wr(4'd5, 12'h100); chk("R4 dir set", pad_oe, 12'h10F);
        wr(4'd6, 12'h003); chk("R4 dir clr", pad_oe, 12'h10C);
    endtask

    task automatic t_periph;
        per_out = 12'hFFF; per_oe = 12'h0F0;
        wr(4'd0, 12'hF0F);
        chk("R3 pad_oe", pad_oe, 12'h1FC);
        chk("R3 pad_out", pad_out, 12'h0F4);
        per_oe = 12'h000; #1;
        chk("R3 per_oe follow", pad_oe, 12'h10C);
        wr(4'd0, 12'hFFF);
        per_out = '0;
    endtask

    task automatic t_latency;
        pad_in = 12'h001;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R9 per_in", per_in, 12'h001);
        rd(4'd9); chk("R5 pin before third edge", rv, 12'h000);
        rd(4'd9); chk("R5 pin after third edge", rv, 12'h001);
        chk("R7 irq masked off", {11'b0, irq}, '0);
        rd(4'd10); chk("R8 stat read", rv, 12'h001);
        rd(4'd10); chk("R8 stat cleared", rv, 12'h000);
    endtask

    task automatic t_filter;
        wr(4'd7, 12'h002);
        pad_in = 12'h007;
        @(posedge clk); @(negedge clk);
        pad_in = 12'h001;
        idle(6);
        rd(4'd9);  chk("R6 glitch rejected in pin", rv, 12'h001);
        rd(4'd10); chk("R6 filtered glitch no status, raw glitch status", rv, 12'h004);
        pad_in = 12'h003;
        @(posedge clk); @(posedge clk); @(negedge clk);
        rd(4'd9); chk("R6 filtered before third edge", rv, 12'h001);
        rd(4'd9); chk("R6 filtered before fourth edge", rv, 12'h001);
        rd(4'd9); chk("R6 filtered after fourth edge", rv, 12'h003);
        rd(4'd10); chk("R6 filtered change status", rv, 12'h002);
        wr(4'd7, 12'h000);
    endtask

    task automatic t_irq;
        wr(4'd8, 12'h008);
        pad_in = 12'h00B;
        idle(4);
        chk("R7 irq on masked change", {11'b0, irq}, 12'h001);
        wr(4'd8, 12'h000);
        chk("R7 irq masked", {11'b0, irq}, 12'h000);
        wr(4'd8, 12'h008);
        chk("R7 irq unmasked again", {11'b0, irq}, 12'h001);
        rd(4'd10); chk("R8 stat line3", rv, 12'h008);
        chk("R7 irq after clear", {11'b0, irq}, 12'h000);
    endtask

    task automatic t_race;
        wr(4'd8, 12'h030);
        pad_in = 12'h01B;
        idle(4);
        chk("R8 pending irq", {11'b0, irq}, 12'h001);
        pad_in = 12'h03B;
        @(posedge clk); @(posedge clk); @(negedge clk);
        rd(4'd10); chk("R8 race first read", rv, 12'h010);
        chk("R8 irq kept by new event", {11'b0, irq}, 12'h001);
        rd(4'd10); chk("R8 race second read", rv, 12'h020);
        chk("R8 irq after both reads", {11'b0, irq}, 12'h000);
    endtask

    initial begin
        @(posedge clk); @(posedge clk); @(posedge clk); @(negedge clk);
        rst = 1'b0;
        @(posedge clk); @(negedge clk);
        t_reset();
        t_gpio_drive();
        t_setclr();
        t_periph();
        t_latency();
        t_filter();
        t_irq();
        t_race();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule